// File: doc/BRIEF.md
# Real-Time Counter with Alarm and Periodic Tick

This block keeps time for a small system. A 40-bit counter advances by one on every timer clock. It is held as an 8-bit upper word and a 32-bit lower word, and software reads or loads each word through a flat register port. A 40-bit alarm value is compared with the whole count and raises a one-cycle event on equality. A separate reloadable down-counter produces a tick at a programmable rate, so it can serve as the system heartbeat.

The block has three interrupt pulse outputs: counter rollover, alarm hit and periodic tick. Each pulse also sets a sticky bit in a status word, and software clears that bit by writing a 1 to it. The two counter words are read independently and there is no snapshot latch. Software that needs a consistent 40-bit value must read both words twice and repeat until the two reads agree.

Top module: `rtc_alarm_timer`

## Requirements
- R1: The count advances by one on every clock edge. A carry out of the all-ones lower word increments the upper word. A read of address 2 returns the upper word zero-extended to 32 bits, and a read of address 1 returns the lower word.
- R2: While control bit 2 is set, the lower word holds its value. Because the lower word produces no carry, the upper word holds as well.
- R3: While control bit 3 is set, the upper word holds. The lower word keeps counting and wraps past all ones without carrying.
- R4: While control bit 4 is set, both words are held at zero. After software writes that bit to 0, counting resumes from zero, so the lower word reads 5 five cycles after the releasing write.
- R5: When the full 40-bit count steps from all ones to zero, `irq_wrap_o` is high for exactly one cycle. That cycle is the first one in which the count reads zero.
- R6: The alarm words are at addresses 3 (lower) and 4 (upper). A write to address 4 keeps only its low 8 bits. `irq_alarm_o` pulses for one cycle, starting one cycle after the full 40-bit count first equals the alarm. If only the lower word matches, there is no pulse.
- R7: The reload value is at address 5. With control bit 0 set and bit 1 clear, `irq_tick_o` pulses once every reload+1 cycles. The first pulse comes reload+1 cycles after the enabling write.
- R8: No tick is produced while control bit 1 is set or control bit 0 is clear. Writing zero to the control register at address 0 leaves the periodic timer disabled and makes the register read 0.
- R9: The status word is at address 6. Bits 31, 30 and 29 latch the rollover, alarm and tick pulses. Writing 1 to a bit clears only that bit, and a new pulse wins over a clear in the same cycle.
- R10: Writes to addresses 1 and 2 load the counter words on the next clock edge. Reads return live values with no wait state. After reset, the control, alarm, reload and status registers all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_wrap_o | output | 1 | One-cycle pulse on 40-bit rollover |
| irq_alarm_o | output | 1 | One-cycle pulse on alarm match |
| irq_tick_o | output | 1 | One-cycle periodic tick |

## Verification
The counter is loaded just below three boundaries: a lower-word carry, a full 40-bit rollover, and a frozen upper word. Each of these places the expected event at an exact cycle, so an off-by-one in the carry or in the pulse timing shows up as a wrong position. The alarm is exercised twice with the same lower word, once with a matching upper word and once with a different one; this separates a full 40-bit compare from a lower-word-only compare. The periodic timer is swept over reload values 0 to 6, and both the first-tick latency and the tick spacing are checked against reload+1. Freeze, clear and the write-zero disable are each held for a window of cycles, in which the bench confirms that nothing moves.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   typedef enum logic [2:0] {
      RA_CTRL    = 3'd0,
      RA_CNT_LO  = 3'd1,
      RA_CNT_HI  = 3'd2,
      RA_ALM_LO  = 3'd3,
      RA_ALM_HI  = 3'd4,
      RA_RELOAD  = 3'd5,
      RA_STATUS  = 3'd6
   } rtc_addr_e;

   localparam int CTRL_W = 5;

   // control fields, bit 0 upward
   typedef struct packed {
      logic clr;      // bit 4
      logic frz_hi;   // bit 3
      logic frz_lo;   // bit 2
      logic per_frz;  // bit 1
      logic per_en;   // bit 0
   } rtc_ctrl_t;

   localparam int NUM_IRQ  = 3;
   localparam int STAT_LSB = 29;   // tick 29, alarm 30, wrap 31
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
   parameter int HI_W = 8,
   parameter int LO_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_i,
   input  logic            frz_lo_i,
   input  logic            frz_hi_i,
   input  logic            ld_lo_i,
   input  logic            ld_hi_i,
   input  logic [LO_W-1:0] ld_lo_data_i,
   input  logic [HI_W-1:0] ld_hi_data_i,
   output logic [LO_W-1:0] cnt_lo_o,
   output logic [HI_W-1:0] cnt_hi_o,
   output logic            wrap_o
);
   logic lo_step, lo_carry, hi_step, full_wrap;

   initial begin
      assert (HI_W >= 1 && LO_W >= 2) else $error("rtc_counter: bad widths");
   end

   always_comb begin
      lo_step   = !frz_lo_i && !ld_lo_i;
      lo_carry  = lo_step && (&cnt_lo_o);
      hi_step   = lo_carry && !frz_hi_i && !ld_hi_i;
      full_wrap = hi_step && (&cnt_hi_o);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_lo_o <= '0;
         cnt_hi_o <= '0;
         wrap_o   <= 1'b0;
      end else if (clr_i) begin
         cnt_lo_o <= '0;
         cnt_hi_o <= '0;
         wrap_o   <= 1'b0;
      end else begin
         if (ld_lo_i)      cnt_lo_o <= ld_lo_data_i;
         else if (lo_step) cnt_lo_o <= cnt_lo_o + 1'b1;
         if (ld_hi_i)      cnt_hi_o <= ld_hi_data_i;
         else if (hi_step) cnt_hi_o <= cnt_hi_o + 1'b1;
         wrap_o <= full_wrap;
      end
   end

   assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_lo_o == '0 && cnt_hi_o == '0));

   assert_freeze_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && frz_lo_i && !ld_lo_i && !ld_hi_i) |=> ($stable(cnt_lo_o) && $stable(cnt_hi_o)));

   assert_freeze_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && frz_hi_i && !ld_hi_i) |=> $stable(cnt_hi_o));

   assert_wrap_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |-> (cnt_lo_o == '0 && cnt_hi_o == '0));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
   parameter int HI_W = 8,
   parameter int LO_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_lo_i,
   input  logic            wr_hi_i,
   input  logic [LO_W-1:0] wr_lo_data_i,
   input  logic [HI_W-1:0] wr_hi_data_i,
   input  logic [LO_W-1:0] cnt_lo_i,
   input  logic [HI_W-1:0] cnt_hi_i,
   output logic [LO_W-1:0] alm_lo_o,
   output logic [HI_W-1:0] alm_hi_o,
   output logic            hit_o
);
   localparam int FULL_W = HI_W + LO_W;

   logic              equal_now;
   logic              equal_q;
   logic [FULL_W-1:0] cnt_full, alm_full;

   assign cnt_full  = {cnt_hi_i, cnt_lo_i};
   assign alm_full  = {alm_hi_o, alm_lo_o};
   assign equal_now = (cnt_full == alm_full);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alm_lo_o <= '0;
         alm_hi_o <= '0;
         equal_q  <= 1'b1;   // count and alarm both start at zero
         hit_o    <= 1'b0;
      end else begin
         if (wr_lo_i) alm_lo_o <= wr_lo_data_i;
         if (wr_hi_i) alm_hi_o <= wr_hi_data_i;
         equal_q <= equal_now;
         hit_o   <= equal_now && !equal_q;
      end
   end

   assert_hit_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> ($past(cnt_full) == $past(alm_full)));

   assert_hit_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> !hit_o);
endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             frz_i,
   input  logic [PER_W-1:0] reload_i,
   output logic             tick_o
);
   logic [PER_W-1:0] down_q;
   logic             run, at_zero;

   initial begin
      assert (PER_W >= 1) else $error("rtc_periodic: bad width");
   end

   assign run     = en_i && !frz_i;
   assign at_zero = (down_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         down_q <= '0;
         tick_o <= 1'b0;
      end else begin
         tick_o <= run && at_zero;
         if (!en_i)        down_q <= reload_i;
         else if (!frz_i)  down_q <= at_zero ? reload_i : down_q - 1'b1;
      end
   end

   assert_tick_reloads_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> (down_q == $past(reload_i)));

   assert_no_tick_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i || frz_i) |=> !tick_o);
endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer #(
   parameter int HI_W  = 8,
   parameter int LO_W  = 32,
   parameter int PER_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en_i,
   input  logic [2:0]      addr_i,
   input  logic [LO_W-1:0] wdata_i,
   output logic [LO_W-1:0] rdata_o,
   output logic            irq_wrap_o,
   output logic            irq_alarm_o,
   output logic            irq_tick_o
);
   import rtc_pkg::*;

   initial begin
      assert (LO_W >= 32 && HI_W <= LO_W && PER_W <= LO_W)
         else $error("rtc_alarm_timer: widths out of range");
   end

   rtc_ctrl_t        ctrl_q;
   logic [PER_W-1:0] reload_q;
   logic [LO_W-1:0]  cnt_lo, alm_lo;
   logic [HI_W-1:0]  cnt_hi, alm_hi;
   logic [NUM_IRQ-1:0] irq_src, stat_q;

   logic wr_ctrl, wr_cnt_lo, wr_cnt_hi, wr_alm_lo, wr_alm_hi, wr_reload, wr_stat;

   always_comb begin
      wr_ctrl   = wr_en_i && (addr_i == RA_CTRL);
      wr_cnt_lo = wr_en_i && (addr_i == RA_CNT_LO);
      wr_cnt_hi = wr_en_i && (addr_i == RA_CNT_HI);
      wr_alm_lo = wr_en_i && (addr_i == RA_ALM_LO);
      wr_alm_hi = wr_en_i && (addr_i == RA_ALM_HI);
      wr_reload = wr_en_i && (addr_i == RA_RELOAD);
      wr_stat   = wr_en_i && (addr_i == RA_STATUS);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
      end else begin
         if (wr_ctrl)   ctrl_q   <= rtc_ctrl_t'(wdata_i[CTRL_W-1:0]);
         if (wr_reload) reload_q <= wdata_i[PER_W-1:0];
      end
   end

   rtc_counter #(.HI_W(HI_W), .LO_W(LO_W)) u_count (
      .clk(clk), .rst_n(rst_n),
      .clr_i(ctrl_q.clr), .frz_lo_i(ctrl_q.frz_lo), .frz_hi_i(ctrl_q.frz_hi),
      .ld_lo_i(wr_cnt_lo), .ld_hi_i(wr_cnt_hi),
      .ld_lo_data_i(wdata_i), .ld_hi_data_i(wdata_i[HI_W-1:0]),
      .cnt_lo_o(cnt_lo), .cnt_hi_o(cnt_hi), .wrap_o(irq_wrap_o));

   rtc_alarm #(.HI_W(HI_W), .LO_W(LO_W)) u_alarm (
      .clk(clk), .rst_n(rst_n),
      .wr_lo_i(wr_alm_lo), .wr_hi_i(wr_alm_hi),
      .wr_lo_data_i(wdata_i), .wr_hi_data_i(wdata_i[HI_W-1:0]),
      .cnt_lo_i(cnt_lo), .cnt_hi_i(cnt_hi),
      .alm_lo_o(alm_lo), .alm_hi_o(alm_hi), .hit_o(irq_alarm_o));

   rtc_periodic #(.PER_W(PER_W)) u_tick (
      .clk(clk), .rst_n(rst_n),
      .en_i(ctrl_q.per_en), .frz_i(ctrl_q.per_frz), .reload_i(reload_q),
      .tick_o(irq_tick_o));

   // index 0 tick, 1 alarm, 2 wrap -> status bits 29, 30, 31
   assign irq_src = {irq_wrap_o, irq_alarm_o, irq_tick_o};

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 stat_q[g] <= 1'b0;
         else if (irq_src[g])                        stat_q[g] <= 1'b1;
         else if (wr_stat && wdata_i[STAT_LSB + g])  stat_q[g] <= 1'b0;
      end

      assert_sticky_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
         irq_src[g] |=> stat_q[g]);
   end

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         RA_CTRL:   rdata_o[CTRL_W-1:0] = ctrl_q;
         RA_CNT_LO: rdata_o = cnt_lo;
         RA_CNT_HI: rdata_o[HI_W-1:0] = cnt_hi;
         RA_ALM_LO: rdata_o = alm_lo;
         RA_ALM_HI: rdata_o[HI_W-1:0] = alm_hi;
         RA_RELOAD: rdata_o[PER_W-1:0] = reload_q;
         RA_STATUS: rdata_o[STAT_LSB +: NUM_IRQ] = stat_q;
         default:   rdata_o = '0;
      endcase
   end

   assert_irq_exclusive_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_wrap_o |=> !irq_wrap_o);
endmodule

// File: tb/rtc_alarm_timer_test.sv
`timescale 1ns/1ps
module rtc_alarm_timer_test;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        wr_en = 0;
   logic [2:0]  addr = 0;
   logic [31:0] wdata = 0;
   logic [31:0] rdata;
   logic        irq_wrap, irq_alarm, irq_tick;
   int tests = 0, fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   rtc_alarm_timer uut (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .irq_wrap_o(irq_wrap), .irq_alarm_o(irq_alarm), .irq_tick_o(irq_tick));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v0, v1;
      int first, second, cnt;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R10 reset values
      rd(3'd0, v0); check("R10 ctrl reset", v0, 0);
      rd(3'd6, v0); check("R10 status reset", v0, 0);
      rd(3'd4, v0); check("R10 alarm hi reset", v0, 0);
      rd(3'd5, v0); check("R10 reload reset", v0, 0);

      // R1 free running
      rd(3'd1, v0);
      repeat (10) @(negedge clk);
      rd(3'd1, v1);
      check("R1 ten cycles", v1 - v0, 10);

      // R1 / R10 carry into upper word
      wr(3'd2, 32'h5);
      wr(3'd1, 32'hFFFF_FFF0);
      rd(3'd1, v0); check("R10 load lower", v0, 32'hFFFF_FFF0);
      repeat (16) @(negedge clk);
      rd(3'd1, v0); check("R1 lower wrapped", v0, 0);
      rd(3'd2, v0); check("R1 upper carried", v0, 6);

      // R2 freeze lower
      wr(3'd0, 32'h04);
      rd(3'd1, v0); rd(3'd2, v1);
      repeat (10) @(negedge clk);
      rd(3'd1, rdata_hold); check("R2 lower held", rdata_hold, v0);
      rd(3'd2, rdata_hold); check("R2 upper held", rdata_hold, v1);

      // R3 freeze upper
      wr(3'd0, 32'h08);
      wr(3'd2, 32'h7);
      wr(3'd1, 32'hFFFF_FFFE);
      repeat (4) @(negedge clk);
      rd(3'd1, v0); check("R3 lower runs", v0, 2);
      rd(3'd2, v0); check("R3 upper held", v0, 7);

      // R4 clear
      wr(3'd0, 32'h10);
      repeat (3) @(negedge clk);
      rd(3'd1, v0); check("R4 lower zero", v0, 0);
      rd(3'd2, v0); check("R4 upper zero", v0, 0);
      wr(3'd0, 32'h0);
      repeat (5) @(negedge clk);
      rd(3'd1, v0); check("R4 resumes", v0, 5);

      // R5 rollover
      wr(3'd6, 32'hE000_0000);
      wr(3'd2, 32'hFF);
      wr(3'd1, 32'hFFFF_FFFA);
      first = -1; cnt = 0;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         if (irq_wrap) begin cnt++; first = k; end
         if (k == 6) begin
            rd(3'd1, v0); check("R5 count zero lower", v0, 0);
            rd(3'd2, v0); check("R5 count zero upper", v0, 0);
         end
         if (k == 7) begin
            rd(3'd6, v0); check("R9 wrap status bit31", v0[31], 1);
         end
      end
      check("R5 pulse count", cnt, 1);
      check("R5 pulse cycle", first, 6);
      wr(3'd6, 32'h8000_0000);
      rd(3'd6, v0); check("R9 wrap cleared", v0[31], 0);

      // R6 alarm
      wr(3'd4, 32'hABCD_0012);
      rd(3'd4, v0); check("R6 upper masked", v0, 32'h12);
      wr(3'd3, 32'h100);
      wr(3'd2, 32'h13);
      wr(3'd1, 32'hF0);
      cnt = 0;
      for (int k = 1; k <= 24; k++) begin
         @(negedge clk);
         if (irq_alarm) cnt++;
      end
      check("R6 lower-only no hit", cnt, 0);
      wr(3'd2, 32'h12);
      wr(3'd1, 32'hF0);
      first = -1; cnt = 0;
      for (int k = 1; k <= 24; k++) begin
         @(negedge clk);
         if (irq_alarm) begin cnt++; first = k; end
      end
      check("R6 one hit", cnt, 1);
      check("R6 hit cycle", first, 17);
      rd(3'd6, v0); check("R9 alarm status bit30", v0[30], 1);

      // R7 periodic sweep
      for (int r = 0; r <= 6; r++) begin
         wr(3'd0, 32'h0);
         wr(3'd5, r);
         wr(3'd0, 32'h1);
         first = -1; second = -1;
         for (int k = 1; k <= 3 * (r + 1) + 2; k++) begin
            @(negedge clk);
            if (irq_tick) begin
               if (first < 0) first = k;
               else if (second < 0) second = k;
            end
         end
         check($sformatf("R7 first tick reload=%0d", r), first, r + 1);
         check($sformatf("R7 spacing reload=%0d", r), second - first, r + 1);
      end

      // R8 freeze, then write-zero disable
      wr(3'd0, 32'h3);
      cnt = 0;
      for (int k = 1; k <= 30; k++) begin @(negedge clk); if (irq_tick) cnt++; end
      check("R8 frozen no tick", cnt, 0);
      wr(3'd0, 32'h1);
      repeat (5) @(negedge clk);
      wr(3'd0, 32'h0);
      cnt = 0;
      for (int k = 1; k <= 30; k++) begin @(negedge clk); if (irq_tick) cnt++; end
      check("R8 disabled no tick", cnt, 0);
      rd(3'd0, v0); check("R8 ctrl reads zero", v0, 0);

      // R9 selective clear
      wr(3'd6, 32'h2000_0000);
      rd(3'd6, v0);
      check("R9 tick bit cleared", v0[29], 0);
      check("R9 alarm bit kept", v0[30], 1);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   logic [31:0] rdata_hold;
endmodule